// File: doc/BRIEF.md
# Gated-Latch Interrupt Controller

This block gathers single-cycle event strobes from neighbouring units, such as timers and line detectors, and records them in three 8-bit pending banks. Each pending bank is paired with an 8-bit enable bank. An enable bit decides whether its event is recorded at all; it does not mask a bit that is already pending. Once a pending bit is set, it stays set until software clears it by writing a one to it. Writing a zero to a pending bit changes nothing, so software can clear one source at a time while several sources are pending.

A flat register port gives access to the six banks. Writes are single-cycle strobes and reads are combinational. The active-low interrupt line is low whenever any pending bit is set. The thirteen sources fill bit 0 upward of the first bank and then the second bank. All other bit positions read as zero.

Top module: `irq_gated_latch_ctrl`

## Requirements
- R1: After a synchronous reset, every pending bit and every enable bit is 0 and `irq_n_o` is high.
- R2: A strobe on `evt_i[k]` while enable bit k is 1 sets pending bit k at the next clock edge. Source k lives in bank k/8 at bit k%8. Pending bank b is read and written at address b, and enable bank b at address 4+b. Reads are combinational.
- R3: A strobe on a source whose enable bit is 0 leaves that source's pending bit at 0.
- R4: A write to a pending bank clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: `irq_n_o` is low exactly while at least one pending bit is set, and it stays low until the last pending bit is cleared.
- R6: If a source strobe and a clearing write for the same bit fall in the same cycle, the bit ends up set.
- R7: Writing 0 to an enable bit does not clear a pending bit that is already set.
- R8: Bit positions above source 12 and all of bank 2 always read 0, even after ones are written to their enable bits. Addresses 3 and 7 read 0, and writes to them have no effect.
- R9: When an enable write and a strobe on the same source fall in one cycle, the strobe is gated by the enable value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 13 | Single-cycle event strobes, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Two functions can land on the same bit in the same cycle. A source strobe can meet a clearing write to its pending bit, and a source strobe can meet a write to its enable bit. The bench provokes both by raising the strobe and the write strobe in one clock period. It then reads the pending bank back: in the first case the bit must be set, and in the second case the bit must follow the enable value held before the write. A clearing write that lands on a bit already set is also sent together with a fresh event, and the bit must still be set afterwards.

// File: rtl/irq_gl_pkg.sv
package irq_gl_pkg;

    localparam int BANK_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int IDX_W    = 2;

    // Decoded view of a register address
    typedef struct packed {
        logic             hit_pend;
        logic             hit_ena;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    // Address bit 2 selects the enable banks, bits 1:0 pick the bank
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.hit_pend = ~a[2];
        s.hit_ena  =  a[2];
        s.idx      =  a[1:0];
        return s;
    endfunction

    // Bits of bank b that carry a real source
    function automatic logic [BANK_W-1:0] live_mask(input int b, input int nsrc);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) begin
            m[i] = ((b * BANK_W + i) < nsrc);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_gl_bank.sv
module irq_gl_bank
    import irq_gl_pkg::*;
#(
    parameter logic [BANK_W-1:0] LIVE = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] evt,
    input  logic [BANK_W-1:0] clr,
    input  logic              ena_we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] pend,
    output logic [BANK_W-1:0] ena
);

    logic [BANK_W-1:0] pend_nx;
    logic [BANK_W-1:0] ena_nx;

    always_comb begin
        // set has priority over clear; gating uses the enable held now
        pend_nx = ((pend & ~clr) | (evt & ena)) & LIVE;
        ena_nx  = ena_we ? (wdata & LIVE) : ena;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            ena  <= '0;
        end else begin
            pend <= pend_nx;
            ena  <= ena_nx;
        end
    end

endmodule

// File: rtl/irq_gl_rdmux.sv
module irq_gl_rdmux
    import irq_gl_pkg::*;
#(
    parameter int NUM_BANK = 3
) (
    input  logic [NUM_BANK*BANK_W-1:0] pend_flat,
    input  logic [NUM_BANK*BANK_W-1:0] ena_flat,
    input  reg_sel_t                   sel,
    output logic [BANK_W-1:0]          rdata
);

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (sel.idx == IDX_W'(b)) begin
                if (sel.hit_pend) rdata = pend_flat[b*BANK_W +: BANK_W];
                if (sel.hit_ena)  rdata = ena_flat[b*BANK_W +: BANK_W];
            end
        end
    end

endmodule

// File: rtl/irq_gated_latch_ctrl.sv
module irq_gated_latch_ctrl
    import irq_gl_pkg::*;
#(
    parameter int NUM_SRC  = 13,
    parameter int NUM_BANK = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  evt_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [BANK_W-1:0]   wdata_i,
    output logic [BANK_W-1:0]   rdata_o,
    output logic                irq_n_o
);

    localparam int TOT = NUM_BANK * BANK_W;

    logic [TOT-1:0] evt_pad;
    logic [TOT-1:0] pend_flat;
    logic [TOT-1:0] ena_flat;
    logic [TOT-1:0] clr_flat;
    reg_sel_t       sel;

    assign evt_pad = TOT'(evt_i);
    assign sel     = decode_addr(addr_i);

    genvar b;
    generate
        for (b = 0; b < NUM_BANK; b++) begin : g_bank
            localparam logic [BANK_W-1:0] LIVE_B = live_mask(b, NUM_SRC);
            logic hit_b;
            logic ena_we_b;

            assign hit_b    = wr_en_i && (sel.idx == IDX_W'(b));
            assign ena_we_b = hit_b && sel.hit_ena;
            assign clr_flat[b*BANK_W +: BANK_W] =
                (hit_b && sel.hit_pend) ? wdata_i : '0;

            irq_gl_bank #(
                .LIVE (LIVE_B)
            ) u_bank (
                .clk    (clk),
                .rst    (rst),
                .evt    (evt_pad[b*BANK_W +: BANK_W]),
                .clr    (clr_flat[b*BANK_W +: BANK_W]),
                .ena_we (ena_we_b),
                .wdata  (wdata_i),
                .pend   (pend_flat[b*BANK_W +: BANK_W]),
                .ena    (ena_flat[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    irq_gl_rdmux #(
        .NUM_BANK (NUM_BANK)
    ) u_rdmux (
        .pend_flat (pend_flat),
        .ena_flat  (ena_flat),
        .sel       (sel),
        .rdata     (rdata_o)
    );

    assign irq_n_o = ~(|pend_flat);

endmodule

// File: rtl/irq_gated_latch_chk.sv
module irq_gated_latch_chk #(
    parameter int TOT = 24
) (
    input logic           clk,
    input logic           rst,
    input logic [TOT-1:0] evt_pad,
    input logic [TOT-1:0] ena_flat,
    input logic [TOT-1:0] pend_flat,
    input logic [TOT-1:0] clr_flat,
    input logic           irq_n_o
);

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (pend_flat == '0 && ena_flat == '0 && irq_n_o)); // R1

    AST_ENABLED_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_flat & $past(evt_pad & ena_flat)) == $past(evt_pad & ena_flat))); // R2

    AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_flat & ~$past(pend_flat) & ~$past(evt_pad & ena_flat)) == '0)); // R3

    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_flat & $past(clr_flat & ~(evt_pad & ena_flat))) == '0)); // R4

    AST_HOLD_UNCLEARED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_flat & ~clr_flat) & ~pend_flat) == '0)); // R7

    AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (rst)
        (|(evt_pad & ena_flat & clr_flat)) |=> (|pend_flat)); // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o && ((pend_flat & ~clr_flat) != '0)) |=> !irq_n_o); // R5

endmodule

bind irq_gated_latch_ctrl irq_gated_latch_chk #(
    .TOT (NUM_BANK * 8)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pad   (evt_pad),
    .ena_flat  (ena_flat),
    .pend_flat (pend_flat),
    .clr_flat  (clr_flat),
    .irq_n_o   (irq_n_o)
);

// File: tb/irq_gated_latch_ctrl_tb.sv
module irq_gated_latch_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 13;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] evt_i = '0;
    logic            wr_en_i = 1'b0;
    logic [2:0]      addr_i = '0;
    logic [7:0]      wdata_i = '0;
    logic [7:0]      rdata_o;
    logic            irq_n_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_gated_latch_ctrl dut_i (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_n_o (irq_n_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Combinational read, sampled between edges
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    // One-cycle write, optionally with an event strobe in the same cycle
    task automatic wr_evt(input logic [2:0] a, input logic [7:0] d,
                          input logic do_wr, input logic [NSRC-1:0] ev);
        @(negedge clk);
        addr_i  = a;
        wdata_i = d;
        wr_en_i = do_wr;
        evt_i   = ev;
        @(negedge clk);
        wr_en_i = 1'b0;
        evt_i   = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_evt(a, d, 1'b1, '0);
    endtask

    task automatic pulse(input logic [NSRC-1:0] ev);
        wr_evt(3'd0, 8'h00, 1'b0, ev);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg zero", d, 8'h00);
        end
        check("R1 irq_n high", {7'd0, irq_n_o}, 8'h01);
    endtask

    task automatic t_enabled_set;
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'h05);
        wr(3'd5, 8'h10);
        pulse(13'h1005);            // sources 0, 2, 12
        rd(3'd0, d); check("R2 bank0 pending", d, 8'h05);
        rd(3'd1, d); check("R2 bank1 pending src12", d, 8'h10);
        check("R5 irq_n low", {7'd0, irq_n_o}, 8'h00);
    endtask

    task automatic t_disabled;
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'h01);
        pulse(13'h00FE);            // sources 1..7, disabled
        rd(3'd0, d); check("R3 disabled ignored", d, 8'h00);
        check("R3 irq_n stays high", {7'd0, irq_n_o}, 8'h01);
    endtask

    task automatic t_clear_indiv;
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'h0F);
        pulse(13'h000F);
        wr(3'd0, 8'h00);
        rd(3'd0, d); check("R4 zero write no effect", d, 8'h0F);
        wr(3'd0, 8'h05);
        rd(3'd0, d); check("R4 partial clear", d, 8'h0A);
        check("R5 irq_n low while pending", {7'd0, irq_n_o}, 8'h00);
        wr(3'd0, 8'h08);
        check("R5 irq_n low one left", {7'd0, irq_n_o}, 8'h00);
        wr(3'd0, 8'h02);
        rd(3'd0, d); check("R4 all cleared", d, 8'h00);
        check("R5 irq_n high when empty", {7'd0, irq_n_o}, 8'h01);
    endtask

    task automatic t_collision;
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'h03);
        wr_evt(3'd0, 8'h01, 1'b1, 13'h0001);   // fresh event + clear
        rd(3'd0, d); check("R6 fresh collide sets", d, 8'h01);
        wr_evt(3'd0, 8'h03, 1'b1, 13'h0001);   // pending bit + clear + event
        rd(3'd0, d); check("R6 collide keeps set", d, 8'h01);
    endtask

    task automatic t_enable_drop;
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'h40);
        pulse(13'h0040);
        wr(3'd4, 8'h00);
        rd(3'd0, d); check("R7 pending survives disable", d, 8'h40);
        rd(3'd4, d); check("R7 enable reads 0", d, 8'h00);
        pulse(13'h0040);
        wr(3'd0, 8'h40);
        rd(3'd0, d); check("R7 cleared no re-set", d, 8'h00);
    endtask

    task automatic t_unused;
        logic [7:0] d;
        do_reset();
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        rd(3'd5, d); check("R8 bank1 enable mask", d, 8'h1F);
        rd(3'd6, d); check("R8 bank2 enable zero", d, 8'h00);
        pulse('1);
        rd(3'd1, d); check("R8 bank1 pending mask", d, 8'h1F);
        rd(3'd2, d); check("R8 bank2 pending zero", d, 8'h00);
        wr(3'd3, 8'hFF);
        wr(3'd7, 8'hFF);
        rd(3'd3, d); check("R8 addr3 reads 0", d, 8'h00);
        rd(3'd7, d); check("R8 addr7 reads 0", d, 8'h00);
        rd(3'd0, d); check("R8 addr3 write no clear", d, 8'hFF);
        rd(3'd4, d); check("R8 addr7 write no enable change", d, 8'hFF);
    endtask

    task automatic t_same_cycle_en;
        logic [7:0] d;
        do_reset();
        wr_evt(3'd4, 8'h08, 1'b1, 13'h0008);   // enable + event together
        rd(3'd0, d); check("R9 old enable 0 gates", d, 8'h00);
        wr_evt(3'd4, 8'h00, 1'b1, 13'h0008);   // disable + event together
        rd(3'd0, d); check("R9 old enable 1 passes", d, 8'h08);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_enabled_set();
                t_disabled();
                t_clear_indiv();
                t_collision();
                t_enable_drop();
                t_unused();
                t_same_cycle_en();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule